// File: doc/BRIEF.md
# Segmented Bidirectional Ring Interconnect

This block is a ring network that links twelve ports. Each port can send one 16-byte beat to any other port. The ring has four unidirectional lanes. Two lanes move data towards higher port numbers (clockwise) and two move data towards lower port numbers (counter-clockwise). For each request, the ring picks the shorter direction around the loop. It then looks for a lane in that direction whose segments along the path are all free. Segments on a lane are reserved per transfer, so up to three transfers whose paths do not overlap can share one lane at the same time.

The ring logic runs at half the system clock. A toggling phase bit enables arbitration and hop movement on every second system clock edge. A granted beat moves one hop per ring clock. When it reaches its destination, the destination port sees a one-cycle delivery strobe together with the source index and the data. A requester holds its valid bit, destination and data until it sees its grant pulse.

Top module: `seg_ring`

## Requirements
- R1: While reset is active and after reset is released with no requests, `req_grant` and `dlv_valid` stay all zero.
- R2: Port i's destination is `req_dst[i]`. Let d = (dst - i) mod 12, where clockwise means increasing port number. If d is 1 to 6, the transfer goes clockwise over d hops; a distance of exactly 6 goes clockwise. Otherwise it goes counter-clockwise over 12 - d hops.
- R3: Port dst sees `dlv_valid[dst]` exactly 2*hops system clocks after the grant pulse. In that cycle, `dlv_src[dst]` holds the source index and `dlv_data[dst]` holds the granted data.
- R4: Grants and deliveries change only on every second system clock. Each grant pulse and each delivery strobe lasts exactly one system clock.
- R5: A request is granted only if every segment on its path is free on one of the two lanes of its direction. Those segments stay reserved until delivery. They can be reused at the ring clock after the delivery.
- R6: One lane carries at most three transfers at a time, so at most six transfers can be in flight per direction.
- R7: At most one transfer can be in flight towards any destination. A second request to a busy destination waits until the first transfer is delivered.
- R8: Each ring clock, requests are examined in order starting from a round-robin pointer. The pointer is 0 after reset. After a ring clock with grants, the pointer moves to one past the last requester granted.
- R9: A request whose destination equals its own index, or is 12 or more, is never granted. Such a request does not block other requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 12 | Per-port request valid, held until the grant pulse |
| req_dst | input | 12x4 | Per-port destination index |
| req_data | input | 12x128 | Per-port 16-byte payload |
| req_grant | output | 12 | One-cycle per-port grant pulse |
| dlv_valid | output | 12 | One-cycle per-port delivery strobe |
| dlv_src | output | 12x4 | Source index of the delivered beat, per destination |
| dlv_data | output | 12x128 | Delivered payload, per destination |

## Verification
The hardest state to reach is a full lane pair, where a request is refused only because of segment overlap or slot exhaustion and not because of a busy destination. The bench sets up two overlapping clockwise transfers that take both clockwise lanes. It then raises a six-hop request that is a direction tie, so its grant time shows which way it was routed. A second scenario raises all twelve single-hop requests at once. This fills all six clockwise slots and shows both the three-per-lane limit and the round-robin order through the grant masks and the gap of two ring clocks between them.

// File: rtl/seg_ring.sv
module seg_ring #(
  parameter int NODES         = 12,
  parameter int DATA_W        = 128,
  parameter int LANES_PER_DIR = 2,
  parameter int SLOTS         = 3,
  parameter int ID_W          = $clog2(NODES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NODES-1:0]                 req_valid,
  input  logic [NODES-1:0][ID_W-1:0]       req_dst,
  input  logic [NODES-1:0][DATA_W-1:0]     req_data,
  output logic [NODES-1:0]                 req_grant,
  output logic [NODES-1:0]                 dlv_valid,
  output logic [NODES-1:0][ID_W-1:0]       dlv_src,
  output logic [NODES-1:0][DATA_W-1:0]     dlv_data
);
  localparam int HALF  = NODES / 2;
  localparam int LANES = 2 * LANES_PER_DIR;
  localparam int HOP_W = $clog2(HALF + 1);
  localparam int SL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LN_W  = $clog2(LANES);

  logic tick;
  logic [ID_W-1:0] rr_ptr;

  logic [LANES-1:0][SLOTS-1:0]             s_v;
  logic [LANES-1:0][SLOTS-1:0][ID_W-1:0]   s_src, s_dst;
  logic [LANES-1:0][SLOTS-1:0][HOP_W-1:0]  s_hop;
  logic [LANES-1:0][SLOTS-1:0][NODES-1:0]  s_seg;
  logic [LANES-1:0][SLOTS-1:0][DATA_W-1:0] s_dat;

  logic [NODES-1:0]             gnt;
  logic [NODES-1:0][LN_W-1:0]   g_lane;
  logic [NODES-1:0][SL_W-1:0]   g_slot;
  logic [NODES-1:0][NODES-1:0]  g_seg;
  logic [NODES-1:0][HOP_W-1:0]  g_hop;
  logic [ID_W-1:0]              nxt_ptr;

  logic [LANES-1:0][NODES-1:0]  a_seg;
  logic [LANES-1:0][SLOTS-1:0]  a_used;
  logic [NODES-1:0]             a_dst;
  logic [NODES-1:0]             a_mask;
  logic                         a_cw, a_placed;
  int                           a_r, a_dv, a_d, a_hops, a_l;

  function automatic logic [NODES-1:0] path_of(input int src, input int hops, input logic cw);
    logic [NODES-1:0] m;
    m = '0;
    for (int i = 0; i < HALF; i++)
      if (i < hops) m[cw ? (src + i) % NODES : (src + NODES - i) % NODES] = 1'b1;
    return m;
  endfunction

  always_comb begin
    a_seg  = '0;
    a_used = s_v;
    a_dst  = '0;
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < SLOTS; s++)
        if (s_v[l][s]) begin
          a_seg[l]            = a_seg[l] | s_seg[l][s];
          a_dst[s_dst[l][s]]  = 1'b1;
        end
    gnt = '0; g_lane = '0; g_slot = '0; g_seg = '0; g_hop = '0;
    nxt_ptr = rr_ptr;
    a_mask = '0; a_cw = 1'b0; a_placed = 1'b0;
    a_r = 0; a_dv = 0; a_d = 0; a_hops = 0; a_l = 0;
    for (int k = 0; k < NODES; k++) begin
      a_r  = (int'(rr_ptr) + k) % NODES;
      a_dv = int'(req_dst[a_r]);
      if (req_valid[a_r] && a_dv < NODES && a_dv != a_r && !a_dst[req_dst[a_r]]) begin
        a_d      = (a_dv - a_r + NODES) % NODES;
        a_cw     = (a_d <= HALF);
        a_hops   = a_cw ? a_d : NODES - a_d;
        a_mask   = path_of(a_r, a_hops, a_cw);
        a_placed = 1'b0;
        for (int j = 0; j < LANES_PER_DIR; j++) begin
          a_l = a_cw ? j : LANES_PER_DIR + j;
          if (!a_placed && (a_seg[a_l] & a_mask) == '0)
            for (int s = 0; s < SLOTS; s++)
              if (!a_placed && !a_used[a_l][s]) begin
                a_placed       = 1'b1;
                a_used[a_l][s] = 1'b1;
                a_seg[a_l]     = a_seg[a_l] | a_mask;
                gnt[a_r]       = 1'b1;
                g_lane[a_r]    = LN_W'(a_l);
                g_slot[a_r]    = SL_W'(s);
                g_seg[a_r]     = a_mask;
                g_hop[a_r]     = HOP_W'(a_hops);
              end
        end
        if (a_placed) begin
          a_dst[req_dst[a_r]] = 1'b1;
          nxt_ptr = ID_W'((a_r + 1) % NODES);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick      <= 1'b0;
      rr_ptr    <= '0;
      req_grant <= '0;
      dlv_valid <= '0;
      dlv_src   <= '0;
      dlv_data  <= '0;
      s_v       <= '0;
      s_src     <= '0;
      s_dst     <= '0;
      s_hop     <= '0;
      s_seg     <= '0;
      s_dat     <= '0;
    end else begin
      tick      <= ~tick;
      req_grant <= '0;
      dlv_valid <= '0;
      if (tick) begin
        for (int l = 0; l < LANES; l++)
          for (int s = 0; s < SLOTS; s++)
            if (s_v[l][s]) begin
              if (s_hop[l][s] == HOP_W'(1)) begin
                s_v[l][s]                <= 1'b0;
                dlv_valid[s_dst[l][s]]   <= 1'b1;
                dlv_src[s_dst[l][s]]     <= s_src[l][s];
                dlv_data[s_dst[l][s]]    <= s_dat[l][s];
              end else begin
                s_hop[l][s] <= s_hop[l][s] - HOP_W'(1);
              end
            end
        for (int r = 0; r < NODES; r++)
          if (gnt[r]) begin
            s_v  [g_lane[r]][g_slot[r]] <= 1'b1;
            s_src[g_lane[r]][g_slot[r]] <= ID_W'(r);
            s_dst[g_lane[r]][g_slot[r]] <= req_dst[r];
            s_hop[g_lane[r]][g_slot[r]] <= g_hop[r];
            s_seg[g_lane[r]][g_slot[r]] <= g_seg[r];
            s_dat[g_lane[r]][g_slot[r]] <= req_data[r];
          end
        req_grant <= gnt;
        rr_ptr    <= nxt_ptr;
      end
    end
  end
endmodule

// File: rtl/seg_ring_chk.sv
module seg_ring_chk #(
  parameter int NODES = 12,
  parameter int ID_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NODES-1:0]           req_valid,
  input logic [NODES-1:0][ID_W-1:0] req_dst,
  input logic [NODES-1:0]           req_grant,
  input logic [NODES-1:0]           dlv_valid
);
  // R4
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant != '0) |=> (req_grant == '0));

  // R4
  dlv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid != '0) |=> (dlv_valid == '0));

  for (genvar i = 0; i < NODES; i++) begin : g_port
    // R8
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[i] |-> $past(req_valid[i]));

    // R9
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[i] |-> ($past(req_dst[i]) != ID_W'(i) && int'($past(req_dst[i])) < NODES));
  end
endmodule

bind seg_ring seg_ring_chk #(.NODES(NODES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
  .req_grant(req_grant), .dlv_valid(dlv_valid)
);

// File: tb/tb_seg_ring.sv
module tb_seg_ring;
  localparam int N = 12;
  localparam int W = 128;
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 1, 1}, '{0, 11, 1}, '{3, 9, 6}, '{9, 3, 6},
    '{5, 0, 5}, '{7, 2, 5}, '{1, 6, 5}, '{11, 0, 1}
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0][3:0] req_dst = '0;
  logic [N-1:0][W-1:0] req_data = '0;
  logic [N-1:0] req_grant, dlv_valid;
  logic [N-1:0][3:0] dlv_src;
  logic [N-1:0][W-1:0] dlv_data;
  int cyc = 0, nchk = 0, nfail = 0;

  seg_ring dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_data(req_data), .req_grant(req_grant), .dlv_valid(dlv_valid),
    .dlv_src(dlv_src), .dlv_data(dlv_data));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL R3 watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int s, input int d, input int n);
    return {W/32{32'(s * 65536 + d * 256 + n + 32'h5a000000)}};
  endfunction

  task automatic do_reset();
    rst_n = 0; req_valid = '0;
    repeat (3) @(negedge clk);
    check(req_grant == '0 && dlv_valid == '0, "R1", "outputs in reset", int'(req_grant), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic one_xfer(input int s, input int d, input int hops, input int n);
    int gc, dc;
    req_dst[s] = 4'(d); req_data[s] = pat(s, d, n); req_valid[s] = 1'b1;
    do @(negedge clk); while (!req_grant[s]);
    gc = cyc; req_valid[s] = 1'b0;
    @(negedge clk);
    check(!req_grant[s], "R4", "grant pulse width", int'(req_grant[s]), 0);
    while (!dlv_valid[d]) @(negedge clk);
    dc = cyc;
    check(dc - gc == 2 * hops, "R2 R3", "latency", dc - gc, 2 * hops);
    check(dlv_src[d] == 4'(s), "R3", "delivered source", int'(dlv_src[d]), s);
    check(dlv_data[d] == pat(s, d, n), "R3", "delivered data", int'(dlv_data[d][31:0]), int'(pat(s, d, n)));
    @(negedge clk);
    check(!dlv_valid[d], "R4", "strobe width", int'(dlv_valid[d]), 0);
  endtask

  initial begin
    int g1, g2;
    logic [N-1:0] seen;
    do_reset();
    repeat (4) @(negedge clk);
    check(req_grant == '0 && dlv_valid == '0, "R1", "idle after reset", int'(dlv_valid), 0);

    for (int v = 0; v < NV; v++) one_xfer(VEC[v][0], VEC[v][1], VEC[v][2], v);

    // R6 R8: twelve single-hop clockwise requests
    do_reset();
    for (int i = 0; i < N; i++) begin
      req_dst[i] = 4'((i + 1) % N); req_data[i] = pat(i, (i + 1) % N, 40);
    end
    req_valid = '1;
    do @(negedge clk); while (req_grant == '0);
    g1 = cyc;
    check(req_grant == 12'h03F, "R6", "first grant mask", int'(req_grant), 'h03F);
    req_valid = req_valid & ~req_grant;
    do @(negedge clk); while (req_grant == '0);
    g2 = cyc;
    check(req_grant == 12'hFC0, "R8", "second grant mask", int'(req_grant), 'hFC0);
    check(g2 - g1 == 4, "R5", "slot reuse gap", g2 - g1, 4);
    req_valid = '0;
    repeat (6) @(negedge clk);

    // R2 R5: six-hop tie blocked on both clockwise lanes
    do_reset();
    req_dst[0] = 4'd5; req_dst[1] = 4'd6; req_valid[1:0] = 2'b11;
    do @(negedge clk); while (req_grant == '0);
    g1 = cyc;
    check(req_grant[1:0] == 2'b11, "R5", "both lanes granted", int'(req_grant), 3);
    req_valid[1:0] = 2'b00;
    req_dst[2] = 4'd8; req_data[2] = pat(2, 8, 50); req_valid[2] = 1'b1;
    do @(negedge clk); while (!req_grant[2]);
    check(cyc - g1 == 12, "R2", "tie routed clockwise", cyc - g1, 12);
    req_valid[2] = 1'b0;
    repeat (16) @(negedge clk);

    // R7: two sources to one destination
    do_reset();
    req_dst[0] = 4'd3; req_dst[6] = 4'd3; req_valid[0] = 1'b1; req_valid[6] = 1'b1;
    do @(negedge clk); while (req_grant == '0);
    g1 = cyc;
    check(req_grant == 12'h001, "R7", "single grant to busy dst", int'(req_grant), 1);
    req_valid[0] = 1'b0;
    do @(negedge clk); while (!req_grant[6]);
    check(cyc - g1 == 8, "R7", "second grant after delivery", cyc - g1, 8);
    req_valid[6] = 1'b0;
    repeat (10) @(negedge clk);

    // R9: illegal destinations
    do_reset();
    req_dst[3] = 4'd3; req_dst[4] = 4'd12; req_dst[5] = 4'd6; req_valid[5:3] = 3'b111;
    seen = '0;
    repeat (16) begin
      @(negedge clk);
      seen = seen | req_grant;
      if (req_grant[5]) req_valid[5] = 1'b0;
    end
    check(seen[4:3] == 2'b00, "R9", "illegal never granted", int'(seen[4:3]), 0);
    check(seen[5], "R9", "legal neighbour granted", int'(seen[5]), 1);
    req_valid = '0;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule